// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Engine

This block is the device-side command front end of a serial NOR flash, limited to the block-erase path. It listens to a SPI mode 0 link (clock idle low, data captured on the rising clock edge, data launched on the falling edge). While chip select is low it shifts in an opcode and a 24-bit address. It keeps a write-enable latch and checks the addressed block against a 3-bit protect field. When all checks pass, it hands a one-cycle erase request to an external array port and then runs a self-timed busy period.

Three commands are understood: write-enable, block erase and read-status. A host polls the busy state through the status byte, which repeats for as long as chip select stays low. The SPI pins are sampled by the system clock and must be synchronous to it. The link clock must be at most a quarter of the system clock. The busy period lasts `ERASE_CYCLES` system clocks.

Top module: `flash_erase_front`

## Requirements
- R1: After reset the status byte reads 00h with the protect input at zero, `spiMiso` is 0 and `eraseStb` is 0.
- R2: Opcode 06h followed by chip select rising after exactly 8 bits sets the write-enable latch, which is status bit 1.
- R3: Opcode D8h or 52h, a 24-bit address sent MSB first, and chip select rising after exactly 32 bits (latch set, block unprotected) produce the erase request. `eraseStb` is high for exactly one clock, on the clock after the one that first samples chip select high. `eraseBlk` equals address bits 19:16, and `eraseFill` is FFh. Address bits 23:20 have no effect.
- R4: An erase sent while the write-enable latch is clear is ignored: no strobe, and the busy bit stays 0.
- R5: If chip select rises at any bit count other than 32, the erase is discarded: no strobe, no busy, and the write-enable latch is unchanged.
- R6: An accepted erase sets the busy bit (status bit 0) for exactly `ERASE_CYCLES` clocks, starting on the same clock as the strobe decision. The write-enable latch clears at the start of that period.
- R7: A nonzero protect value N locks the top 2^(N-1) of the 16 blocks (all of them when N is 5 or more). An erase aimed at a locked block gives no strobe and no busy, and the write-enable latch stays set.
- R8: Opcode 05h returns the status byte MSB first, shifted on falling clock edges. The layout is: bit 0 busy, bit 1 write-enable latch, bits 4:2 the protect value, bits 7:5 zero. The byte repeats while chip select stays low.
- R9: While the busy bit is 1, write-enable and erase commands are ignored. Read-status still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSck | input | 1 | SPI clock, mode 0, synchronous to clk |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data into the device |
| spiMiso | output | 1 | Serial data out of the device (status) |
| protBits | input | 3 | Block-protect value (test load) |
| eraseStb | output | 1 | One-cycle erase request to the array port |
| eraseBlk | output | 4 | Index of the block to erase |
| eraseFill | output | 8 | Fill byte for the erased block (FFh) |

## Verification
The erase request is due one clock after the clock that first samples chip select high, so the bench drives chip select on a falling clock edge. It then checks `eraseStb`, `eraseBlk` and `eraseFill` at the next falling edge, and checks that the strobe is gone one edge later. A status bit is captured when the first falling SPI clock of each status byte reaches the design, one system clock after that edge. The bench therefore samples `spiMiso` just before each rising SPI clock. The busy period is bracketed from the strobe clock: one read is placed so that its capture falls inside the last 30 clocks of `ERASE_CYCLES`, and a second read starts right after the period ends. Every output is read on the falling system-clock edge.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_ERASE_A = 8'hD8;
  localparam logic [7:0] OP_ERASE_B = 8'h52;
  localparam logic [7:0] OP_RDSTAT  = 8'h05;

  // strobes and live flags from control to datapath
  typedef struct packed {
    logic launch;
    logic wip;
    logic wel;
  } ctrl_strobes_t;

  // nonzero prot N locks the top 2^(N-1) blocks out of nBlk
  function automatic logic blockLocked(input int unsigned blk,
                                       input logic [2:0] prot,
                                       input int unsigned nBlk);
    int unsigned span;
    if (prot == 3'd0) return 1'b0;
    span = 32'd1 << (prot - 3'd1);
    return (blk + span) >= nBlk;
  endfunction

endpackage

// File: rtl/erase_datapath.sv
module erase_datapath
  import flash_erase_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int BLOCK_LSB  = 16,
  parameter int BLOCK_BITS = 4,
  localparam int FRAME_BITS = 8 + ADDR_BITS,
  localparam int CNT_W      = $clog2(FRAME_BITS + 2) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  spiSck,
  input  logic                  spiCsN,
  input  logic                  spiMosi,
  input  ctrl_strobes_t         strobes,
  input  logic [2:0]            protBits,
  output logic                  spiMiso,
  output logic                  csRise,
  output logic [CNT_W-1:0]      bitCnt,
  output logic [FRAME_BITS-1:0] cmdWord,
  output logic                  eraseStb,
  output logic [BLOCK_BITS-1:0] eraseBlk,
  output logic [7:0]            eraseFill
);

  logic sckQ, csQ;
  logic sckRise, sckFall, csFall;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [7:0] opReg;
  logic [6:0] txReg;
  logic [2:0] txCnt;
  logic statusMode;
  logic [7:0] statusByte;

  assign sckRise = spiSck & ~sckQ;
  assign sckFall = ~spiSck & sckQ;
  assign csFall  = ~spiCsN & csQ;
  assign csRise  = spiCsN & ~csQ;

  assign statusMode = (opReg == OP_RDSTAT) && (bitCnt >= CNT_W'(8));
  assign statusByte = {3'b000, protBits, strobes.wel, strobes.wip};
  assign cmdWord    = shiftReg;
  assign eraseFill  = 8'hFF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      csQ  <= 1'b1;
    end else begin
      sckQ <= spiSck;
      csQ  <= spiCsN;
    end
  end

  // frame capture and status shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      opReg    <= '0;
      txReg    <= '0;
      txCnt    <= '0;
      spiMiso  <= 1'b0;
    end else if (csFall) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      opReg    <= '0;
      txReg    <= '0;
      txCnt    <= '0;
      spiMiso  <= 1'b0;
    end else if (csRise) begin
      spiMiso <= 1'b0;
    end else if (!spiCsN) begin
      if (sckRise) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], spiMosi};
        if (bitCnt != '1) bitCnt <= bitCnt + CNT_W'(1);
        if (bitCnt == CNT_W'(7)) opReg <= {shiftReg[6:0], spiMosi};
      end
      if (sckFall && statusMode) begin
        if (txCnt == 3'd0) begin
          spiMiso <= statusByte[7];
          txReg   <= statusByte[6:0];
        end else begin
          spiMiso <= txReg[6];
          txReg   <= {txReg[5:0], 1'b0};
        end
        txCnt <= txCnt + 3'd1;
      end
    end
  end

  // erase request to the array port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseStb <= 1'b0;
      eraseBlk <= '0;
    end else begin
      eraseStb <= strobes.launch;
      if (strobes.launch) eraseBlk <= shiftReg[BLOCK_LSB +: BLOCK_BITS];
    end
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseStb |=> !eraseStb);

  // R3
  strobe_after_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseStb |-> csQ);

  // R8
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && $past(csQ)) |-> !spiMiso);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!eraseStb && !spiMiso));

endmodule

// File: rtl/erase_control.sv
module erase_control
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 50000,
  parameter int FRAME_BITS   = 32,
  parameter int CNT_W        = 7,
  parameter int BLOCK_LSB    = 16,
  parameter int BLOCK_BITS   = 4,
  localparam int TMR_W = $clog2(ERASE_CYCLES + 1),
  localparam int NBLK  = 1 << BLOCK_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csRise,
  input  logic [CNT_W-1:0]      bitCnt,
  input  logic [FRAME_BITS-1:0] cmdWord,
  input  logic [2:0]            protBits,
  output ctrl_strobes_t         strobes
);

  logic wip, wel;
  logic [TMR_W-1:0] busyTimer;
  logic [7:0] frameOp;
  logic [BLOCK_BITS-1:0] blkSel;
  logic isEraseOp, locked, wrenHit, eraseHit;

  assign frameOp   = cmdWord[FRAME_BITS-1 -: 8];
  assign blkSel    = cmdWord[BLOCK_LSB +: BLOCK_BITS];
  assign isEraseOp = (frameOp == OP_ERASE_A) || (frameOp == OP_ERASE_B);
  assign locked    = blockLocked(32'(blkSel), protBits, NBLK);

  assign wrenHit  = csRise && !wip && (bitCnt == CNT_W'(8)) && (cmdWord[7:0] == OP_WREN);
  assign eraseHit = csRise && !wip && (bitCnt == CNT_W'(FRAME_BITS)) && isEraseOp
                    && wel && !locked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wip       <= 1'b0;
      wel       <= 1'b0;
      busyTimer <= '0;
    end else if (eraseHit) begin
      wip       <= 1'b1;
      wel       <= 1'b0;
      busyTimer <= TMR_W'(ERASE_CYCLES - 1);
    end else begin
      if (wip) begin
        if (busyTimer == '0) wip <= 1'b0;
        else busyTimer <= busyTimer - TMR_W'(1);
      end
      if (wrenHit) wel <= 1'b1;
    end
  end

  assign strobes.launch = eraseHit;
  assign strobes.wip    = wip;
  assign strobes.wel    = wel;

  // R6
  timer_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> (busyTimer <= TMR_W'(ERASE_CYCLES - 1)));

  // R6
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> !wel);

  // R5
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> ($past(bitCnt) == CNT_W'(FRAME_BITS)));

  // R4
  wel_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel));

  // R7
  unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> !blockLocked(32'($past(blkSel)), $past(protBits), NBLK));

  // R9
  busy_wren_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wip) |-> !$rose(wel));

endmodule

// File: rtl/flash_erase_front.sv
module flash_erase_front
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 50000,
  parameter int ADDR_BITS    = 24,
  parameter int BLOCK_LSB    = 16,
  parameter int BLOCK_BITS   = 4,
  localparam int FRAME_BITS = 8 + ADDR_BITS,
  localparam int CNT_W      = $clog2(FRAME_BITS + 2) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  spiSck,
  input  logic                  spiCsN,
  input  logic                  spiMosi,
  output logic                  spiMiso,
  input  logic [2:0]            protBits,
  output logic                  eraseStb,
  output logic [BLOCK_BITS-1:0] eraseBlk,
  output logic [7:0]            eraseFill
);

  ctrl_strobes_t strobes;
  logic csRise;
  logic [CNT_W-1:0] bitCnt;
  logic [FRAME_BITS-1:0] cmdWord;

  erase_datapath #(
    .ADDR_BITS(ADDR_BITS), .BLOCK_LSB(BLOCK_LSB), .BLOCK_BITS(BLOCK_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .strobes(strobes), .protBits(protBits), .spiMiso(spiMiso), .csRise(csRise),
    .bitCnt(bitCnt), .cmdWord(cmdWord), .eraseStb(eraseStb), .eraseBlk(eraseBlk),
    .eraseFill(eraseFill)
  );

  erase_control #(
    .ERASE_CYCLES(ERASE_CYCLES), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W),
    .BLOCK_LSB(BLOCK_LSB), .BLOCK_BITS(BLOCK_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csRise(csRise), .bitCnt(bitCnt), .cmdWord(cmdWord),
    .protBits(protBits), .strobes(strobes)
  );

endmodule

// File: tb/sim_flash_erase_front.sv
`timescale 1ns/1ps
module sim_flash_erase_front;

  localparam int ERASE = 400;
  localparam int HALF  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSck = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic [2:0] protBits = 3'd0;
  logic spiMiso, eraseStb;
  logic [3:0] eraseBlk;
  logic [7:0] eraseFill;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_erase_front #(.ERASE_CYCLES(ERASE)) u0 (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .protBits(protBits), .eraseStb(eraseStb), .eraseBlk(eraseBlk),
    .eraseFill(eraseFill)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = tx[i];
      waitClk(HALF);
      rx[i] = spiMiso;
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
  endtask

  task automatic csLow();
    @(negedge clk);
    spiCsN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] d;
    csLow();
    xfer(8'h05, d);
    xfer(8'h00, s);
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(2);
  endtask

  // sends op plus nAddr address bytes, raises CS, samples the strobe window
  task automatic issue(input logic [7:0] op, input int nAddr, input logic [31:0] addr,
                       output logic stb, output logic [3:0] blk, output logic [7:0] fill,
                       output logic stbAfter, output int stbCyc);
    logic [7:0] d;
    csLow();
    xfer(op, d);
    for (int b = 0; b < nAddr; b++) xfer(addr[31 - 8*b -: 8], d);
    waitClk(HALF);
    spiCsN = 1'b1;
    @(negedge clk);
    stb = eraseStb; blk = eraseBlk; fill = eraseFill; stbCyc = cyc;
    @(negedge clk);
    stbAfter = eraseStb;
    waitClk(2);
  endtask

  task automatic wren();
    logic s, a; logic [3:0] b; logic [7:0] f; int c;
    issue(8'h06, 0, 32'h0, s, b, f, a, c);
  endtask

  task automatic expectNoErase(input logic [7:0] op, input int nAddr, input logic [23:0] addr,
                               input string req);
    logic s, a; logic [3:0] b; logic [7:0] f; int c;
    issue(op, nAddr, {addr, 8'h00}, s, b, f, a, c);
    check(s == 1'b0 && a == 1'b0, req, "unexpected erase strobe", int'(s), 0);
  endtask

  task automatic expectErase(input logic [7:0] op, input logic [23:0] addr,
                             input logic [3:0] expBlk, output int startCyc);
    logic s, a; logic [3:0] b; logic [7:0] f;
    issue(op, 3, {addr, 8'h00}, s, b, f, a, startCyc);
    check(s == 1'b1, "R3", "erase strobe", int'(s), 1);
    check(b == expBlk, "R3", "block index", int'(b), int'(expBlk));
    check(f == 8'hFF, "R3", "fill byte", int'(f), 8'hFF);
    check(a == 1'b0, "R3", "strobe one cycle", int'(a), 0);
  endtask

  task automatic waitDone(input int startCyc);
    while (cyc < startCyc + ERASE + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check(spiMiso == 1'b0, "R1", "miso after reset", int'(spiMiso), 0);
    check(eraseStb == 1'b0, "R1", "strobe after reset", int'(eraseStb), 0);
    readStatus(s);
    check(s == 8'h00, "R1", "status after reset", int'(s), 0);
  endtask

  task automatic t_wren();
    logic [7:0] s;
    wren();
    readStatus(s);
    check(s == 8'h02, "R2", "WEL after write-enable", int'(s), 8'h02);
  endtask

  task automatic t_eraseBusy();
    logic [7:0] s;
    int st;
    // R3 upper address bits A are ignored
    expectErase(8'hD8, 24'hA51234, 4'd5, st);
    readStatus(s);
    check(s == 8'h01, "R6", "busy set, WEL cleared", int'(s), 8'h01);
    // R9 commands during busy
    wren();
    expectNoErase(8'h52, 3, 24'h020000, "R9");
    readStatus(s);
    check(s == 8'h01, "R9", "WEL stays clear while busy", int'(s), 8'h01);
    while (cyc < st + ERASE - 62) @(negedge clk);
    readStatus(s);
    check(s == 8'h01, "R6", "busy late in the period", int'(s), 8'h01);
    waitDone(st);
    readStatus(s);
    check(s == 8'h00, "R6", "busy clears after period", int'(s), 8'h00);
  endtask

  task automatic t_noWel();
    logic [7:0] s;
    expectNoErase(8'h52, 3, 24'h030000, "R4");
    readStatus(s);
    check(s == 8'h00, "R4", "no busy without WEL", int'(s), 8'h00);
  endtask

  task automatic t_badCount();
    logic [7:0] s;
    int st;
    wren();
    expectNoErase(8'hD8, 2, 24'h070000, "R5");
    readStatus(s);
    check(s == 8'h02, "R5", "short frame keeps WEL", int'(s), 8'h02);
    expectNoErase(8'hD8, 4, 24'h070000, "R5");
    readStatus(s);
    check(s == 8'h02, "R5", "long frame keeps WEL", int'(s), 8'h02);
    expectErase(8'h52, 24'h070000, 4'd7, st);
    waitDone(st);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    int st;
    protBits = 3'd3;
    readStatus(s);
    check(s == 8'h0C, "R8", "protect field in status", int'(s), 8'h0C);
    wren();
    expectNoErase(8'hD8, 3, 24'h0C0000, "R7");
    readStatus(s);
    check(s == 8'h0E, "R7", "locked erase keeps WEL, no busy", int'(s), 8'h0E);
    expectErase(8'hD8, 24'h0B0000, 4'd11, st);
    waitDone(st);
    protBits = 3'd5;
    wren();
    expectNoErase(8'hD8, 3, 24'h000000, "R7");
    protBits = 3'd1;
    expectNoErase(8'h52, 3, 24'h0F0000, "R7");
    expectErase(8'h52, 24'hFE0000, 4'd14, st);
    waitDone(st);
    protBits = 3'd0;
  endtask

  task automatic t_poll();
    logic [7:0] d, s0, s1;
    wren();
    csLow();
    xfer(8'h05, d);
    xfer(8'h00, s0);
    xfer(8'h00, s1);
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(2);
    check(s0 == 8'h02, "R8", "first status byte", int'(s0), 8'h02);
    check(s1 == 8'h02, "R8", "repeated status byte", int'(s1), 8'h02);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    t_reset();
    t_noWel();
    t_wren();
    t_eraseBusy();
    t_badCount();
    t_protect();
    t_poll();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule